// File: doc/BRIEF.md
# Card Configuration Register File

This block holds the four byte-wide configuration registers that a removable storage card exposes in its attribute memory. It also drives the card's interrupt line. A host reaches the block over a simple byte bus with an address, a read strobe, a write strobe and 8-bit data. The registers sit at even offsets above a base address, which is a parameter. A read below that base returns a byte from a read-only card information table. The table contents are generated by a fixed formula that stands in for the real data.

The block takes three inputs from neighbouring logic:
- an interrupt-pending level from the drive core;
- the interrupt-enable bit of the device control register;
- the soft-reset bit of the device control register.

It gives three outputs to the rest of the card:
- the selected address-decode mode;
- a one-cycle soft-reset pulse;
- the registered interrupt level.

The block has two control states, named in the package:
- `S_RUN`: registers accept host writes.
- `S_SOFTRST`: a single cycle in which the soft-reset pulse is driven and the register state is cleared.

There are two transitions:
- `S_RUN` to `S_SOFTRST` is taken on a write to the option register with bit 7 set.
- `S_SOFTRST` to `S_RUN` is taken unconditionally on the next clock.

Top module: `cardcfg_regfile`

## Requirements
- R1: A write to the option register (base+0) stores the data ANDed with 0xCF. `mode_sel` shows stored bits [5:0] from the next cycle onward: 0 means memory-mapped, 1 means 16 contiguous I/O registers, 2 means primary I/O, 3 means secondary I/O.
- R2: An option write with data bit 7 set stores the masked value and moves the FSM to `S_SOFTRST` for one cycle, with `soft_rst` high in that cycle. While `soft_rst` is high, the stored option bit 7 holds the interrupt off. On leaving that cycle, option, status and pin state are all zero, except that the status interrupt bit reloads from `core_intrq`. Host writes in that cycle are ignored.
- R3: A write to the status register (base+2) keeps stored bits 0x82 and loads bits 0x74 from the data. Status bit 0x02 follows `core_intrq` on every clock.
- R4: A status write whose bit 0x04 (power-down) differs from the stored bit sets the card-ready bit 0x20 of the pin register.
- R5: A status read returns the stored byte with bit 0x02 forced to 0 while `devctl_ien` is 1. Otherwise bit 0x02 is returned as stored.
- R6: A pin register read (base+4) returns the card-ready bit 0x20 ORed with 0x0C. A write to it keeps card-ready and loads bit 0x02 from the data.
- R7: Offset 6 reads 0 and ignores writes. Odd or undefined offsets at or above the base also read 0, and writes to them have no effect. Writes below the base have no effect.
- R8: `card_irq` is registered. It is 1 one clock after the following all hold: status bit 0x02 is 0, `devctl_ien` is 0, `devctl_srst` is 0, and stored option bit 7 is 0. It is 0 otherwise, and 0 during reset.
- R9: A read at an address below the base returns (address*7+3) mod 256 when the address is below `TABLE_LEN` (default 0x14A). Otherwise it returns 0.
- R10: Read data is registered: `bus_rdata` takes the read value on the clock edge where `bus_rd` is high, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (10) | Attribute-space byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| core_intrq | input | 1 | Interrupt-pending level from the drive core |
| devctl_ien | input | 1 | Device-control interrupt-enable bit (active high masks) |
| devctl_srst | input | 1 | Device-control soft-reset bit |
| mode_sel | output | 6 | Stored address-decode mode |
| soft_rst | output | 1 | One-cycle soft-reset pulse |
| card_irq | output | 1 | Registered card interrupt level |

## Verification
Internal state in this block is visible at the ports within one or two cycles:
- The option state appears directly on `mode_sel`.
- The interrupt gate appears on `card_irq` one clock after any of its inputs changes.
- A wrong status byte or a wrong card-ready flag appears on `bus_rdata` on the first read after the fault.

A missed or stretched soft-reset shows at once on `soft_rst`. It also shows as stale option and pin contents on the following reads.

The reference model is stepped on every clock, and every output is compared at each step. A divergence is therefore reported in the same cycle in which it reaches a port.

// File: rtl/cardcfg_pkg.sv
package cardcfg_pkg;
    typedef enum logic [2:0] {
        SEL_TABLE,
        SEL_OPT,
        SEL_STAT,
        SEL_PINS,
        SEL_NONE
    } sel_e;

    typedef enum logic {
        S_RUN,
        S_SOFTRST
    } st_e;

    localparam logic [7:0] OPT_WMASK  = 8'hCF;
    localparam logic [7:0] STAT_KEEP  = 8'h82;
    localparam logic [7:0] STAT_LOAD  = 8'h74;
    localparam logic [7:0] PIN_CONST  = 8'h0C;
    localparam int         BIT_INT    = 1;
    localparam int         BIT_PWRDN  = 2;
    localparam int         BIT_READY  = 5;
    localparam int         BIT_OPTRST = 7;
endpackage

// File: rtl/cardcfg_decode.sv
module cardcfg_decode
    import cardcfg_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int ATTR_BASE = 'h200,
    parameter int TABLE_LEN = 'h14A
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [7:0]        tbl_byte
);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(ATTR_BASE);
    localparam logic [ADDR_W-1:0] TLEN_V = ADDR_W'(TABLE_LEN);

    logic [ADDR_W-1:0] off;

    always_comb begin
        off = addr - BASE_V;
        if (addr < BASE_V) begin
            sel = SEL_TABLE;
        end else begin
            unique case (off)
                ADDR_W'(0): sel = SEL_OPT;
                ADDR_W'(2): sel = SEL_STAT;
                ADDR_W'(4): sel = SEL_PINS;
                default:    sel = SEL_NONE;
            endcase
        end
    end

    always_comb begin
        if (addr < TLEN_V) tbl_byte = addr[7:0] * 8'd7 + 8'd3;
        else               tbl_byte = 8'h00;
    end

    // R9: table region lies strictly below the attribute base
    always_comb begin
        a_table_region_r9: assert (!(addr < BASE_V) || sel == SEL_TABLE);
    end
endmodule

// File: rtl/cardcfg_regs.sv
module cardcfg_regs
    import cardcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sel_e       sel,
    input  logic [7:0] tbl_byte,
    input  logic       rd,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       core_intrq,
    input  logic       devctl_ien,
    output logic [7:0] rdata,
    output logic [5:0] mode_sel,
    output logic       soft_rst,
    output logic       stat_int,
    output logic       opt_rst
);
    st_e        state, nxt;
    logic [7:0] opt_q;
    logic [7:0] stat_q;
    logic       ready_q;
    logic       mrdy_q;
    logic [7:0] rdata_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_RUN:     if (wr && sel == SEL_OPT && wdata[BIT_OPTRST]) nxt = S_SOFTRST;
            S_SOFTRST: nxt = S_RUN;
            default:   nxt = S_RUN;
        endcase
    end

    // register contents
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opt_q   <= '0;
            stat_q  <= '0;
            ready_q <= 1'b0;
            mrdy_q  <= 1'b0;
        end else begin
            unique case (state)
                S_RUN: begin
                    if (wr) begin
                        unique case (sel)
                            SEL_OPT: opt_q <= wdata & OPT_WMASK;
                            SEL_STAT: begin
                                if (stat_q[BIT_PWRDN] != wdata[BIT_PWRDN]) ready_q <= 1'b1;
                                stat_q <= (stat_q & STAT_KEEP) | (wdata & STAT_LOAD);
                            end
                            SEL_PINS: mrdy_q <= wdata[1];
                            default: ;
                        endcase
                    end
                end
                S_SOFTRST: begin
                    opt_q   <= '0;
                    stat_q  <= '0;
                    ready_q <= 1'b0;
                    mrdy_q  <= 1'b0;
                end
                default: ;
            endcase
            stat_q[BIT_INT] <= core_intrq;
        end
    end

    // read data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd) begin
            unique case (sel)
                SEL_TABLE: rdata_q <= tbl_byte;
                SEL_OPT:   rdata_q <= opt_q;
                SEL_STAT:  rdata_q <= devctl_ien ? (stat_q & ~8'h02) : stat_q;
                SEL_PINS:  rdata_q <= {2'b00, ready_q, 5'b0} | PIN_CONST;
                default:   rdata_q <= 8'h00;
            endcase
        end
    end

    // outputs
    always_comb begin
        rdata    = rdata_q;
        mode_sel = opt_q[5:0];
        soft_rst = (state == S_SOFTRST);
        stat_int = stat_q[BIT_INT];
        opt_rst  = opt_q[BIT_OPTRST];
    end

    p_opt_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && wr && sel == SEL_OPT) |=> (opt_q == ($past(wdata) & OPT_WMASK)));

    p_softrst_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SOFTRST) |=> (opt_q == 8'h00 && !ready_q && state == S_RUN));

    p_int_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat_q[BIT_INT] == $past(core_intrq)));

    p_pwrdn_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && wr && sel == SEL_STAT && (stat_q[BIT_PWRDN] != wdata[BIT_PWRDN]))
        |=> ready_q);

    p_mrdy_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && wr && sel == SEL_PINS) |=> (mrdy_q == $past(wdata[1])));
endmodule

// File: rtl/cardcfg_irq.sv
module cardcfg_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_int,
    input  logic devctl_ien,
    input  logic devctl_srst,
    input  logic opt_rst,
    output logic card_irq
);
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= !(stat_int || devctl_ien || devctl_srst || opt_rst);
    end

    assign card_irq = irq_q;

    p_irq_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_int || devctl_ien || devctl_srst || opt_rst) |=> !card_irq);

    p_irq_raised_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_int || devctl_ien || devctl_srst || opt_rst) |=> card_irq);
endmodule

// File: rtl/cardcfg_regfile.sv
module cardcfg_regfile
    import cardcfg_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int ATTR_BASE = 'h200,
    parameter int TABLE_LEN = 'h14A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              core_intrq,
    input  logic              devctl_ien,
    input  logic              devctl_srst,
    output logic [5:0]        mode_sel,
    output logic              soft_rst,
    output logic              card_irq
);
    sel_e       sel;
    logic [7:0] tbl_byte;
    logic       stat_int;
    logic       opt_rst;

    cardcfg_decode #(
        .ADDR_W   (ADDR_W),
        .ATTR_BASE(ATTR_BASE),
        .TABLE_LEN(TABLE_LEN)
    ) u_decode (
        .addr    (bus_addr),
        .sel     (sel),
        .tbl_byte(tbl_byte)
    );

    cardcfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .tbl_byte  (tbl_byte),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .wdata     (bus_wdata),
        .core_intrq(core_intrq),
        .devctl_ien(devctl_ien),
        .rdata     (bus_rdata),
        .mode_sel  (mode_sel),
        .soft_rst  (soft_rst),
        .stat_int  (stat_int),
        .opt_rst   (opt_rst)
    );

    cardcfg_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_int   (stat_int),
        .devctl_ien (devctl_ien),
        .devctl_srst(devctl_srst),
        .opt_rst    (opt_rst),
        .card_irq   (card_irq)
    );

    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sim_cardcfg_regfile.sv
`timescale 1ns/1ps
module sim_cardcfg_regfile;
    localparam int BASE = 'h200;
    localparam int TLEN = 'h14A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       core_intrq = 1'b0, devctl_ien = 1'b0, devctl_srst = 1'b0;
    logic [5:0] mode_sel;
    logic       soft_rst, card_irq;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R8";

    // reference model state
    int m_rst_cyc = 0;
    int m_opt = 0, m_stat = 0, m_ready = 0, m_rdata = 0, m_irq = 0;

    always #2 clk = ~clk;

    cardcfg_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_intrq(core_intrq), .devctl_ien(devctl_ien), .devctl_srst(devctl_srst),
        .mode_sel(mode_sel), .soft_rst(soft_rst), .card_irq(card_irq)
    );

    function automatic int read_val(int a);
        int off;
        if (a < BASE) return (a < TLEN) ? ((a * 7 + 3) % 256) : 0;
        off = a - BASE;
        if (off == 0) return m_opt;
        if (off == 2) return devctl_ien ? (m_stat & 'hFD) : m_stat;
        if (off == 4) return (m_ready ? 'h20 : 0) | 'h0C;
        return 0;
    endfunction

    task automatic model_step();
        int n_opt = m_opt, n_stat = m_stat, n_ready = m_ready, n_rst = 0;
        int a = int'(bus_addr);
        int d = int'(bus_wdata);
        m_irq = (((m_stat & 2) == 0) && !devctl_ien && !devctl_srst && ((m_opt & 'h80) == 0)) ? 1 : 0;
        if (bus_rd) m_rdata = read_val(a);
        if (m_rst_cyc != 0) begin
            n_opt = 0; n_stat = 0; n_ready = 0;
        end else if (bus_wr && a >= BASE) begin
            if (a - BASE == 0) begin
                n_opt = d & 'hCF;
                if ((d & 'h80) != 0) n_rst = 1;
            end else if (a - BASE == 2) begin
                if (((m_stat ^ d) & 4) != 0) n_ready = 1;
                n_stat = (m_stat & 'h82) | (d & 'h74);
            end
        end
        n_stat = (n_stat & 'hFD) | (core_intrq ? 2 : 0);
        m_opt = n_opt; m_stat = n_stat; m_ready = n_ready; m_rst_cyc = n_rst;
    endtask

    task automatic cmp(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        cmp("rdata", int'(bus_rdata), m_rdata);
        cmp("mode_sel", int'(mode_sel), m_opt & 'h3F);
        cmp("soft_rst", int'(soft_rst), m_rst_cyc);
        cmp("card_irq", int'(card_irq), m_irq);
    endtask

    task automatic cyc(input logic rd, input logic wr, input int a, input int d);
        bus_rd = rd; bus_wr = wr; bus_addr = 10'(a); bus_wdata = 8'(d);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr_reg(int a, int d); cyc(1'b0, 1'b1, a, d); endtask
    task automatic rd_reg(int a);        cyc(1'b1, 1'b0, a, 0); endtask
    task automatic idle();               cyc(1'b0, 1'b0, 0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R8";
        compare_all();                 // reset state
        rst_n = 1'b1;
        idle(); idle();

        cur_req = "R1";
        wr_reg(BASE, 'h7F); rd_reg(BASE);
        wr_reg(BASE, 'h01); rd_reg(BASE);
        wr_reg(BASE, 'h02); rd_reg(BASE);
        wr_reg(BASE, 'h03); rd_reg(BASE); idle();

        cur_req = "R3";
        core_intrq = 1'b1;
        wr_reg(BASE + 2, 'hFF); rd_reg(BASE + 2);
        wr_reg(BASE + 2, 'h00); rd_reg(BASE + 2);
        core_intrq = 1'b0; idle(); rd_reg(BASE + 2);

        cur_req = "R4";
        rd_reg(BASE + 4);
        wr_reg(BASE + 2, 'h04); rd_reg(BASE + 4);
        wr_reg(BASE + 2, 'h04); rd_reg(BASE + 4);

        cur_req = "R5";
        core_intrq = 1'b1; idle();
        devctl_ien = 1'b1; rd_reg(BASE + 2); idle();
        devctl_ien = 1'b0; rd_reg(BASE + 2);
        core_intrq = 1'b0; idle();

        cur_req = "R6";
        wr_reg(BASE + 4, 'hFF); rd_reg(BASE + 4);
        wr_reg(BASE + 4, 'h00); rd_reg(BASE + 4);

        cur_req = "R2";
        wr_reg(BASE, 'h8A);            // pulse cycle follows
        wr_reg(BASE + 2, 'h74);        // ignored during pulse
        rd_reg(BASE); rd_reg(BASE + 2); rd_reg(BASE + 4); idle();

        cur_req = "R7";
        wr_reg(BASE + 6, 'hFF); rd_reg(BASE + 6);
        wr_reg(BASE + 1, 'h03); rd_reg(BASE); rd_reg(BASE + 1);
        wr_reg(BASE + 3, 'h74); rd_reg(BASE + 2); rd_reg(BASE + 8);
        wr_reg(5, 'h55); rd_reg(BASE); rd_reg(BASE + 2);

        cur_req = "R9";
        rd_reg(0); rd_reg(5); rd_reg(TLEN - 1); rd_reg(TLEN); rd_reg(BASE - 1);

        cur_req = "R10";
        rd_reg(37); idle(); idle(); rd_reg(BASE + 4); idle();

        cur_req = "R8";
        core_intrq = 1'b1; idle(); idle();
        core_intrq = 1'b0; idle(); idle();
        devctl_srst = 1'b1; idle(); idle();
        devctl_srst = 1'b0; idle();
        devctl_ien = 1'b1; idle(); idle();
        devctl_ien = 1'b0; idle(); idle();
        wr_reg(BASE, 'h80); idle(); idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule